// File: doc/BRIEF.md
# Load/Store Bus Watchpoint Combiner

This block watches the processor's load/store bus for debug purposes. Four reference registers feed four equality comparators. Two comparators look at the bus address and two look at the bus data. For each of two watchpoints, a control register picks which comparator result forms the address event and which forms the data event: the first comparator, the second, both, or either. Each event can be marked "don't care". A watchpoint counts as hit when three things hold together on a valid bus cycle: its instruction-side condition, its address event and its data event.

A hit is recognised only when the global masking rule allows it. In masked mode, a hit needs the recoverable-interrupt flag to be set. In non-masked mode, a hit is always recognised. A recognised hit produces a one-cycle registered pulse on that watchpoint's development-port trap, on its software trap, or on both, as the enables allow. The software-side enables sit in the control register. The development-port enables can only be loaded through a separate debug strobe. A sticky status register records which watchpoints were hit and is cleared by a write.

Top module: `ldstw_top`

## Requirements
- R1: After reset, all reference registers, the control register, both development-port trap enables, the status bits and all trap outputs are 0. Because the cleared control register marks every event as don't care and enables no trap, a valid bus cycle with instrCond=11 and msrRecov=1 then sets hitStatus to 11 but pulses no trap.
- R2: Each address comparator checks busAddr for equality against its own reference. Comparator E uses the reference at register address 0 and comparator F the one at address 1. The 2-bit address selector of a watchpoint picks the address match as follows: 00 = E, 01 = F, 10 = E AND F, 11 = E OR F.
- R3: The data event works the same way over busData. Comparator G uses the reference at address 2 and comparator H the one at address 3. Selector codes: 00 = G, 01 = H, 10 = G AND H, 11 = G OR H.
- R4: Each address event and each data event has a care bit. When the bit is 0, the event counts as satisfied whatever the comparators report. When it is 1, the selected match is required.
- R5: A watchpoint is hit only on a cycle where busValid is 1, its instrCond bit is 1, its address event holds and its data event holds.
- R6: The non-mask bit controls recognition. When it is 0, a hit is recognised only while msrRecov is 1. When it is 1, a hit is recognised whatever msrRecov is.
- R7: The development-port trap enables change only on a cycle with dbgWrEn=1, which loads them from dbgTrapEn (bit i belongs to watchpoint i). No write on the software port changes them.
- R8: For watchpoint i, devTrap[i] is 1 for exactly the cycle after a recognised hit if its development-port enable is set. swTrap[i] behaves the same way with its software enable. The two watchpoints pulse independently, including when both are hit in the same cycle and when hits come on back-to-back cycles.
- R9: Bit i of hitStatus becomes 1 on the edge that ends a recognised hit of watchpoint i, whatever the trap enables are, and stays set. A write to register address 5 clears both bits. If a hit falls in the same cycle as that write, the bit for that hit is set.
- R10: A write on the software port (regWrEn=1) takes effect on the same edge. A bus cycle sampled at that edge still uses the old values. The control register is at address 4, with this layout:
  - watchpoint 0: address selector in bits 1:0, address care in bit 2, data selector in bits 4:3, data care in bit 5;
  - watchpoint 1: the same fields in bits 11:6;
  - non-mask bit in bit 12;
  - software trap enables in bits 13 (watchpoint 0) and 14 (watchpoint 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Load/store bus cycle valid |
| busAddr | input | 32 | Bus address |
| busData | input | 32 | Bus data |
| instrCond | input | 2 | Instruction-side condition per watchpoint |
| msrRecov | input | 1 | Recoverable-interrupt flag |
| regWrEn | input | 1 | Software register write strobe |
| regWrAddr | input | 3 | Software register address |
| regWrData | input | 32 | Software register write data |
| dbgWrEn | input | 1 | Debug-side strobe that loads the development-port trap enables |
| dbgTrapEn | input | 2 | Development-port trap enable values |
| devTrap | output | 2 | Development-port trap pulse per watchpoint |
| swTrap | output | 2 | Software trap pulse per watchpoint |
| hitStatus | output | 2 | Sticky record of hit watchpoints |

## Verification
Two functions can land on the same edge.

- Both watchpoints can hit together. The bench provokes this by marking every event of both watchpoints as don't care, or by making their selected comparators match the same bus value. It then expects separate pulses on each enabled trap bit.
- A status-clearing write can coincide with a fresh hit. The bench drives the write to address 5 in the very cycle of a qualifying bus access, and judges the result against its own model, where the new hit overrides the clear.

A scoreboard works out the expected traps and status for every cycle and compares them one cycle later.

// File: rtl/ldstw_pkg.sv
package ldstw_pkg;
  localparam int NUM_WP  = 2;
  localparam int NUM_CMP = 4;
  localparam int REG_AW  = 3;
  localparam logic [REG_AW-1:0] ADR_CTRL   = 3'd4;
  localparam logic [REG_AW-1:0] ADR_STATUS = 3'd5;

  typedef enum logic [1:0] {
    SEL_FIRST  = 2'b00,
    SEL_SECOND = 2'b01,
    SEL_BOTH   = 2'b10,
    SEL_EITHER = 2'b11
  } evtSel_t;

  typedef struct packed {
    logic    dataCare;
    evtSel_t dataSel;
    logic    addrCare;
    evtSel_t addrSel;
  } wpCfg_t;

  typedef struct packed {
    logic [NUM_WP-1:0] swEn;
    logic              nonMask;
    wpCfg_t            wp1;
    wpCfg_t            wp0;
  } ctrlReg_t;

  localparam int CTRL_W = $bits(ctrlReg_t);

  typedef struct packed {
    logic [NUM_CMP-1:0] loadRef;
    logic               loadCtrl;
    logic               clearStatus;
    logic               loadDbg;
  } ldstwStrobe_t;
endpackage

// File: rtl/ldstw_evtsel.sv
module ldstw_evtsel
  import ldstw_pkg::*;
(
  input  logic    hitFirst,
  input  logic    hitSecond,
  input  evtSel_t sel,
  input  logic    care,
  output logic    eventOk
);
  logic picked;

  always_comb begin
    unique case (sel)
      SEL_FIRST:  picked = hitFirst;
      SEL_SECOND: picked = hitSecond;
      SEL_BOTH:   picked = hitFirst & hitSecond;
      default:    picked = hitFirst | hitSecond;
    endcase
    eventOk = !care || picked;
  end
endmodule

// File: rtl/ldstw_datapath.sv
module ldstw_datapath
  import ldstw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int WR_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ldstwStrobe_t       strobe,
  input  logic [WR_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busData,
  output logic [NUM_CMP-1:0] cmpHit
);
  for (genvar g = 0; g < NUM_CMP; g++) begin : gCmp
    if (g < 2) begin : gAddr
      logic [ADDR_W-1:0] refVal;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 refVal <= '0;
        else if (strobe.loadRef[g]) refVal <= wrData[ADDR_W-1:0];
      end
      assign cmpHit[g] = (busAddr == refVal);
    end else begin : gData
      logic [DATA_W-1:0] refVal;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 refVal <= '0;
        else if (strobe.loadRef[g]) refVal <= wrData[DATA_W-1:0];
      end
      assign cmpHit[g] = (busData == refVal);
    end
  end
endmodule

// File: rtl/ldstw_ctrl.sv
module ldstw_ctrl
  import ldstw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regWrAddr,
  input  logic [CTRL_W-1:0]  ctrlWrData,
  input  logic               dbgWrEn,
  input  logic [NUM_WP-1:0]  dbgTrapEn,
  input  logic               busValid,
  input  logic [NUM_WP-1:0]  instrCond,
  input  logic               msrRecov,
  input  logic [NUM_CMP-1:0] cmpHit,
  output ldstwStrobe_t       strobe,
  output logic [NUM_WP-1:0]  devTrap,
  output logic [NUM_WP-1:0]  swTrap,
  output logic [NUM_WP-1:0]  hitStatus
);
  ctrlReg_t          ctrlReg;
  logic [NUM_WP-1:0] devEn;
  logic [NUM_WP-1:0] addrOk, dataOk, fire;
  logic              recognise;

  always_comb begin
    for (int i = 0; i < NUM_CMP; i++)
      strobe.loadRef[i] = regWrEn && (regWrAddr == REG_AW'(i));
    strobe.loadCtrl    = regWrEn && (regWrAddr == ADR_CTRL);
    strobe.clearStatus = regWrEn && (regWrAddr == ADR_STATUS);
    strobe.loadDbg     = dbgWrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ctrlReg <= '0;
    else if (strobe.loadCtrl) ctrlReg <= ctrlReg_t'(ctrlWrData);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              devEn <= '0;
    else if (strobe.loadDbg) devEn <= dbgTrapEn;
  end

  assign recognise = ctrlReg.nonMask || msrRecov;

  for (genvar w = 0; w < NUM_WP; w++) begin : gWp
    wpCfg_t cfg;
    assign cfg = (w == 0) ? ctrlReg.wp0 : ctrlReg.wp1;

    ldstw_evtsel u_addrSel (
      .hitFirst (cmpHit[0]),
      .hitSecond(cmpHit[1]),
      .sel      (cfg.addrSel),
      .care     (cfg.addrCare),
      .eventOk  (addrOk[w])
    );

    ldstw_evtsel u_dataSel (
      .hitFirst (cmpHit[2]),
      .hitSecond(cmpHit[3]),
      .sel      (cfg.dataSel),
      .care     (cfg.dataCare),
      .eventOk  (dataOk[w])
    );

    assign fire[w] = busValid && instrCond[w] && recognise && addrOk[w] && dataOk[w];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devTrap   <= '0;
      swTrap    <= '0;
      hitStatus <= '0;
    end else begin
      devTrap   <= fire & devEn;
      swTrap    <= fire & ctrlReg.swEn;
      hitStatus <= (strobe.clearStatus ? '0 : hitStatus) | fire;
    end
  end
endmodule

// File: rtl/ldstw_top.sv
module ldstw_top
  import ldstw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic [31:0] busAddr,
  input  logic [31:0] busData,
  input  logic [1:0]  instrCond,
  input  logic        msrRecov,
  input  logic        regWrEn,
  input  logic [2:0]  regWrAddr,
  input  logic [31:0] regWrData,
  input  logic        dbgWrEn,
  input  logic [1:0]  dbgTrapEn,
  output logic [1:0]  devTrap,
  output logic [1:0]  swTrap,
  output logic [1:0]  hitStatus
);
  ldstwStrobe_t       strobe;
  logic [NUM_CMP-1:0] cmpHit;

  ldstw_datapath #(.ADDR_W(32), .DATA_W(32)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (regWrData),
    .busAddr(busAddr),
    .busData(busData),
    .cmpHit (cmpHit)
  );

  ldstw_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .ctrlWrData(regWrData[CTRL_W-1:0]),
    .dbgWrEn   (dbgWrEn),
    .dbgTrapEn (dbgTrapEn),
    .busValid  (busValid),
    .instrCond (instrCond),
    .msrRecov  (msrRecov),
    .cmpHit    (cmpHit),
    .strobe    (strobe),
    .devTrap   (devTrap),
    .swTrap    (swTrap),
    .hitStatus (hitStatus)
  );
endmodule

// File: rtl/ldstw_chk.sv
module ldstw_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic [1:0]  instrCond,
  input logic        msrRecov,
  input logic        regWrEn,
  input logic [2:0]  regWrAddr,
  input logic [31:0] regWrData,
  input logic        dbgWrEn,
  input logic [1:0]  dbgTrapEn,
  input logic [1:0]  devTrap,
  input logic [1:0]  swTrap,
  input logic [1:0]  hitStatus
);
  logic       nmShadow;
  logic [1:0] devShadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmShadow  <= 1'b0;
      devShadow <= 2'b00;
    end else begin
      if (regWrEn && regWrAddr == 3'd4) nmShadow <= regWrData[12];
      if (dbgWrEn) devShadow <= dbgTrapEn;
    end
  end

  for (genvar w = 0; w < 2; w++) begin : gW
    // R5
    trap_needs_qualified_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
      (devTrap[w] || swTrap[w]) |-> $past(busValid && instrCond[w]));
    // R6
    trap_respects_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
      (devTrap[w] || swTrap[w]) |-> $past(nmShadow || msrRecov));
    // R7
    dev_trap_needs_dbg_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
      devTrap[w] |-> $past(devShadow[w]));
    // R9
    trap_marks_status_chk: assert property (@(posedge clk) disable iff (!rstN)
      (devTrap[w] || swTrap[w]) |-> hitStatus[w]);
    // R9
    status_rise_from_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(hitStatus[w]) |-> $past(busValid && instrCond[w]));
  end
endmodule

bind ldstw_top ldstw_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .instrCond(instrCond),
  .msrRecov (msrRecov),
  .regWrEn  (regWrEn),
  .regWrAddr(regWrAddr),
  .regWrData(regWrData),
  .dbgWrEn  (dbgWrEn),
  .dbgTrapEn(dbgTrapEn),
  .devTrap  (devTrap),
  .swTrap   (swTrap),
  .hitStatus(hitStatus)
);

// File: tb/ldstw_top_bench.sv
module ldstw_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic [31:0] busData = '0;
  logic [1:0]  instrCond = '0;
  logic        msrRecov = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic        dbgWrEn = 1'b0;
  logic [1:0]  dbgTrapEn = '0;
  logic [1:0]  devTrap, swTrap, hitStatus;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  bit done = 0;

  typedef struct {
    int         due;
    logic [1:0] dev;
    logic [1:0] sw;
    logic [1:0] st;
    string      req;
  } expItem_t;
  expItem_t expQ[$];

  logic [31:0] mRef[4];
  logic [14:0] mCtrl;
  logic [1:0]  mDev, mStat;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  ldstw_top u_ldstw_top (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr), .busData(busData),
    .instrCond(instrCond), .msrRecov(msrRecov), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .dbgWrEn(dbgWrEn), .dbgTrapEn(dbgTrapEn),
    .devTrap(devTrap), .swTrap(swTrap), .hitStatus(hitStatus)
  );

  task automatic check2(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b (cycle %0d)", req, what, act, exp, cycleCnt);
    end
  endtask

  function automatic bit evOk(bit a, bit b, logic [1:0] s, bit care);
    bit m;
    case (s)
      2'b00: m = a;
      2'b01: m = b;
      2'b10: m = a & b;
      default: m = a | b;
    endcase
    return !care || m;
  endfunction

  // Driver: one cycle of stimulus, expected result pushed for the next edge
  task automatic cycleOp(input bit valid, input logic [31:0] a, input logic [31:0] d,
                         input logic [1:0] ic, input bit msr,
                         input bit wr, input logic [2:0] wa, input logic [31:0] wd,
                         input bit dbg, input logic [1:0] dv, input string req);
    expItem_t it;
    logic [1:0] fire;
    @(negedge clk);
    busValid = valid; busAddr = a; busData = d; instrCond = ic; msrRecov = msr;
    regWrEn = wr; regWrAddr = wa; regWrData = wd; dbgWrEn = dbg; dbgTrapEn = dv;
    for (int w = 0; w < 2; w++) begin
      logic [5:0] c;
      c = mCtrl[6*w +: 6];
      fire[w] = valid && ic[w] && (mCtrl[12] || msr)
             && evOk(a == mRef[0], a == mRef[1], c[1:0], c[2])
             && evOk(d == mRef[2], d == mRef[3], c[4:3], c[5]);
    end
    it.due = cycleCnt + 1;
    it.dev = fire & mDev;
    it.sw  = fire & mCtrl[14:13];
    it.st  = ((wr && wa == 3'd5) ? 2'b00 : mStat) | fire;
    it.req = req;
    expQ.push_back(it);
    mStat = it.st;
    if (wr && wa < 3'd4) mRef[wa] = wd;
    if (wr && wa == 3'd4) mCtrl = wd[14:0];
    if (dbg) mDev = dv;
  endtask

  task automatic regWrite(input logic [2:0] wa, input logic [31:0] wd, input string req);
    cycleOp(0, '0, '0, 2'b00, 0, 1, wa, wd, 0, 2'b00, req);
  endtask

  task automatic busOp(input logic [31:0] a, input logic [31:0] d, input logic [1:0] ic,
                       input bit msr, input string req);
    cycleOp(1, a, d, ic, msr, 0, 3'd0, '0, 0, 2'b00, req);
  endtask

  function automatic logic [5:0] cfg(logic [1:0] as, bit ac, logic [1:0] ds, bit dc);
    return {dc, ds, ac, as};
  endfunction

  function automatic logic [31:0] ctrlWord(logic [5:0] c0, logic [5:0] c1, bit nm, logic [1:0] sw);
    return {17'd0, sw, nm, c1, c0};
  endfunction

  // Monitor: pop and compare as results come out
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0 && expQ[0].due <= cycleCnt) begin
        expItem_t it;
        it = expQ.pop_front();
        check2(it.req, "devTrap", devTrap, it.dev);
        check2(it.req, "swTrap", swTrap, it.sw);
        check2(it.req, "hitStatus", hitStatus, it.st);
      end
    end
  end

  // Watchdog
  initial begin
    wait (cycleCnt > 50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mRef[i] = '0;
    mCtrl = '0; mDev = '0; mStat = '0;
    repeat (3) @(negedge clk);
    check2("R1", "devTrap in reset", devTrap, 2'b00);
    check2("R1", "swTrap in reset", swTrap, 2'b00);
    check2("R1", "hitStatus in reset", hitStatus, 2'b00);
    rstN = 1'b1;
    // R1: cleared control means don't-care events and no enabled traps
    busOp(32'h1234, 32'h5678, 2'b11, 1, "R1");
    regWrite(3'd5, '0, "R9");
    // R10: references
    regWrite(3'd0, 32'h0000_A000, "R10");
    regWrite(3'd1, 32'h0000_A004, "R10");
    regWrite(3'd2, 32'hD000_0000, "R10");
    regWrite(3'd3, 32'hD000_0001, "R10");
    cycleOp(0, '0, '0, 2'b00, 0, 0, 3'd0, '0, 1, 2'b01, "R7");
    // R2: every address selector code against E, F and a miss
    for (int s = 0; s < 4; s++) begin
      regWrite(3'd4, ctrlWord(cfg(2'(s), 1, 2'b00, 0), cfg(2'(3 - s), 1, 2'b00, 0), 0, 2'b11), "R2");
      busOp(32'h0000_A000, 32'h0, 2'b11, 1, "R2");
      busOp(32'h0000_A004, 32'h0, 2'b11, 1, "R2");
      busOp(32'h0000_BEEF, 32'h0, 2'b11, 1, "R2");
      regWrite(3'd5, '0, "R9");
    end
    // R2: E AND F with equal references
    regWrite(3'd1, 32'h0000_A000, "R2");
    regWrite(3'd4, ctrlWord(cfg(2'b10, 1, 2'b00, 0), cfg(2'b10, 1, 2'b00, 0), 0, 2'b11), "R2");
    busOp(32'h0000_A000, 32'h0, 2'b01, 1, "R2");
    regWrite(3'd1, 32'h0000_A004, "R2");
    // R3 and R4: data selector codes with address don't care
    for (int s = 0; s < 4; s++) begin
      regWrite(3'd4, ctrlWord(cfg(2'b00, 0, 2'(s), 1), cfg(2'b01, 0, 2'(s ^ 1), 1), 0, 2'b11), "R3");
      busOp(32'h0000_0777, 32'hD000_0000, 2'b11, 1, "R3");
      busOp(32'h0000_0777, 32'hD000_0001, 2'b11, 1, "R3");
      busOp(32'h0000_0777, 32'h0BAD_0000, 2'b11, 1, "R4");
      regWrite(3'd5, '0, "R9");
    end
    // R4: care on both fields
    regWrite(3'd4, ctrlWord(cfg(2'b00, 1, 2'b00, 1), cfg(2'b11, 1, 2'b11, 1), 0, 2'b11), "R4");
    busOp(32'h0000_A000, 32'hD000_0001, 2'b11, 1, "R4");
    busOp(32'h0000_A000, 32'hD000_0000, 2'b11, 1, "R4");
    // R5: no fire without valid or instruction condition
    cycleOp(0, 32'h0000_A000, 32'hD000_0000, 2'b11, 1, 0, 3'd0, '0, 0, 2'b00, "R5");
    regWrite(3'd5, '0, "R9");
    busOp(32'h0000_A000, 32'hD000_0000, 2'b00, 1, "R5");
    busOp(32'h0000_A000, 32'hD000_0000, 2'b10, 1, "R5");
    // R6: masking
    busOp(32'h0000_A000, 32'hD000_0000, 2'b11, 0, "R6");
    regWrite(3'd4, ctrlWord(cfg(2'b00, 1, 2'b00, 1), cfg(2'b11, 1, 2'b11, 1), 1, 2'b11), "R6");
    busOp(32'h0000_A000, 32'hD000_0000, 2'b11, 0, "R6");
    // R7: software writes leave debug enables alone
    regWrite(3'd4, 32'hFFFF_FFFF, "R7");
    regWrite(3'd5, '0, "R9");
    busOp(32'h0000_A000, 32'hD000_0000, 2'b11, 0, "R7");
    cycleOp(0, '0, '0, 2'b00, 0, 0, 3'd0, '0, 1, 2'b10, "R7");
    busOp(32'h0000_A004, 32'hD000_0001, 2'b11, 0, "R7");
    cycleOp(0, '0, '0, 2'b00, 0, 0, 3'd0, '0, 1, 2'b11, "R7");
    // R8: both at once, back to back, then a gap
    regWrite(3'd4, ctrlWord(cfg(2'b00, 0, 2'b00, 0), cfg(2'b00, 0, 2'b00, 0), 1, 2'b11), "R8");
    busOp(32'h1, 32'h2, 2'b11, 0, "R8");
    busOp(32'h3, 32'h4, 2'b01, 0, "R8");
    busOp(32'h5, 32'h6, 2'b10, 0, "R8");
    cycleOp(0, '0, '0, 2'b00, 0, 0, 3'd0, '0, 0, 2'b00, "R8");
    // R9: clear in the same cycle as a hit
    cycleOp(1, 32'h7, 32'h8, 2'b01, 1, 1, 3'd5, '0, 0, 2'b00, "R9");
    regWrite(3'd5, '0, "R9");
    cycleOp(0, '0, '0, 2'b00, 0, 0, 3'd0, '0, 0, 2'b00, "R9");
    // R10: write and bus cycle on the same edge use the old control
    cycleOp(1, 32'h9, 32'h9, 2'b11, 1, 1, 3'd4, 32'h0, 0, 2'b00, "R10");
    busOp(32'h9, 32'h9, 2'b11, 1, "R10");
    repeat (3) cycleOp(0, '0, '0, 2'b00, 0, 0, 3'd0, '0, 0, 2'b00, "R8");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule